// File: doc/BRIEF.md
# Composite Sync Generator with External Sync Presence Detection

The block runs a free-running composite sync timebase for 525-line interlaced video, using either the NTSC or the PAL-M line length. The timebase is clocked from a reference at twice or four times the colour subcarrier. It drives an active-low composite sync pin and two single-clock strobes that downstream character and display logic use to align to line starts and to vertical sync. One set of counters covers both standards and both reference rates.

Position is tracked in units of one eighth of a subcarrier cycle. Each reference clock advances the position by 2 units at 4x or by 4 units at 2x. A line is 1820 units for NTSC and 1818 units for PAL-M. Because of this, an odd half-line length needs no special handling.

Alongside the generator, a detector watches an external horizontal sync pulse and decides whether a stable external source is present. While no external source is present, the block runs on its own timing and asks for a blue background screen. While reset is held, the sync pin carries the raw reference clock.

Top module: `csync_gen`

## Requirements
- R1: While `rst_n` is low, `csync_o` equals `clk`, and `h_strobe`, `v_strobe`, `ext_present` and `blue_bg` are all 0. The timebase restarts at position 0 when reset is released.
- R2: A line lasts `LINE_NTSC` units when `std_sel`=0 (NTSC) and `LINE_PALM` units when `std_sel`=1 (PAL-M). Each clock advances 2 units when `rate_sel`=1 (4x reference) and 4 units when `rate_sel`=0 (2x reference). Two consecutive lines therefore take 2*line/step clocks.
- R3: A frame is split into half-lines; half-line h at position p within it. Outside the vertical interval, `csync_o` is 0 (sync) for p < `HS_TICKS` at the start of every full line (h even) and is 1 everywhere else.
- R4: Within each field, relative half-lines 0..5 and 12..17 are equalizing half-lines. In these, `csync_o` is 0 only for p < `EQ_TICKS`.
- R5: Relative half-lines 6..11 of each field carry broad pulses. In these, `csync_o` is 0 except for the last `SERR_TICKS` units of each half-line.
- R6: A frame has 2*`FRAME_LINES` half-lines. The first field's vertical interval starts at half-line 0. The second field's starts at half-line `FRAME_LINES`, which is the middle of a line.
- R7: `h_strobe` is 1 for exactly the first clock of each full line (h even, p < step). It is 0 at all other times.
- R8: `v_strobe` is 1 for exactly the first clock of relative half-line 6 of each field. This is the leading edge of the broad pulses.
- R9: Interval means the number of clocks between rising edges of `ext_hsync`. The nominal interval is line/step clocks, rounded down. `ext_present` rises after `LOCK_COUNT` (8) consecutive intervals within nominal ± `LOCK_TOL`. The window bounds are inclusive.
- R10: While `ext_present` is 0, an interval outside the window restarts the count of good intervals from zero.
- R11: While `ext_present` is 1, the following rules apply. A window that closes with no edge counts one miss, and the next window is placed one nominal interval later. `ext_present` falls after `MISS_COUNT` (4) consecutive misses. An in-window edge clears the misses. An edge before the window opens is ignored.
- R12: `blue_bg` is 1 exactly when the block is out of reset and `ext_present` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 2x or 4x subcarrier |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_sel | input | 1 | 0 = NTSC line length, 1 = PAL-M line length |
| rate_sel | input | 1 | 1 = 4x reference, 0 = 2x reference |
| ext_hsync | input | 1 | External horizontal sync, active high |
| csync_o | output | 1 | Composite sync, low during sync; the reference clock in reset |
| h_strobe | output | 1 | One-clock pulse at each line start |
| v_strobe | output | 1 | One-clock pulse at the start of vertical sync |
| ext_present | output | 1 | External sync judged present |
| blue_bg | output | 1 | Blue background request (internal timing in use) |

## Verification
The assertions assume that `std_sel` and `rate_sel` change only while reset is held. They also assume that the pulse widths and window tolerance are small compared with a half-line and a nominal interval. The bench changes modes only inside reset and uses widths far below a half-line. It drives `ext_hsync` only from the clocked stimulus thread, with pulses three clocks wide whose spacing is counted in whole clocks. As a result, every interval the detector measures is exactly the spacing the bench chose, including the window edges.

// File: rtl/csg_pkg.sv
package csg_pkg;

  // Position units advanced per reference clock: 4x reference -> 2, 2x -> 4.
  function automatic int unsigned step_of(logic rate4x);
    return rate4x ? 32'd2 : 32'd4;
  endfunction

  function automatic int unsigned line_of(logic palm, int unsigned ln, int unsigned lp);
    return palm ? lp : ln;
  endfunction

  // Field-relative half-line index.
  function automatic int unsigned rel_half(int unsigned hl, int unsigned fl);
    return (hl >= fl) ? hl - fl : hl;
  endfunction

  // Sync level for a given half-line and position (1 = sync active).
  function automatic logic sync_active(int unsigned hl, int unsigned pos, int unsigned half,
                                       int unsigned fl, int unsigned hs, int unsigned eq,
                                       int unsigned serr);
    int unsigned rel;
    rel = rel_half(hl, fl);
    if (rel < 6 || (rel >= 12 && rel < 18)) return pos < eq;
    else if (rel < 12)                      return pos < half - serr;
    else                                    return (hl % 2 == 0) && (pos < hs);
  endfunction

endpackage

// File: rtl/csg_timing.sv
module csg_timing import csg_pkg::*; #(
  parameter int unsigned LINE_NTSC   = 1820,
  parameter int unsigned LINE_PALM   = 1818,
  parameter int unsigned FRAME_LINES = 525,
  parameter int unsigned HS_TICKS    = 135,
  parameter int unsigned EQ_TICKS    = 66,
  parameter int unsigned SERR_TICKS  = 135,
  localparam int unsigned TW = $clog2(LINE_NTSC + 1),
  localparam int unsigned HW = $clog2(2 * FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          std_sel,
  input  logic          rate_sel,
  output logic          sync_act_o,
  output logic          h_strobe_o,
  output logic          v_strobe_o,
  output logic [TW-1:0] pos_o,
  output logic [TW-1:0] half_o
);

  logic [TW-1:0] pos;
  logic [HW-1:0] hl;
  int unsigned   half, step, sum;

  always_comb begin
    half = line_of(std_sel, LINE_NTSC, LINE_PALM) / 2;
    step = step_of(rate_sel);
    sum  = 32'(pos) + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      hl  <= '0;
    end else if (sum >= half) begin
      pos <= TW'(sum - half);
      hl  <= (32'(hl) == 2 * FRAME_LINES - 1) ? '0 : hl + HW'(1);
    end else begin
      pos <= TW'(sum);
    end
  end

  assign sync_act_o = sync_active(32'(hl), 32'(pos), half, FRAME_LINES,
                                  HS_TICKS, EQ_TICKS, SERR_TICKS);
  assign h_strobe_o = !hl[0] && (32'(pos) < step);
  assign v_strobe_o = (rel_half(32'(hl), FRAME_LINES) == 6) && (32'(pos) < step);
  assign pos_o      = pos;
  assign half_o     = TW'(half);

endmodule

// File: rtl/csg_presence.sv
module csg_presence #(
  parameter int unsigned GW         = 11,
  parameter int unsigned LOCK_TOL   = 16,
  parameter int unsigned LOCK_COUNT = 8,
  parameter int unsigned MISS_COUNT = 4,
  localparam int unsigned SW = $clog2(LOCK_COUNT + 1),
  localparam int unsigned MW = $clog2(MISS_COUNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_hsync,
  input  logic [GW-1:0] nominal,
  output logic          present_o,
  output logic          accept_o,
  output logic          miss_o
);

  logic          s1, s2, rise, in_win, locked;
  logic [GW-1:0] gap, lo, hi;
  logic [SW-1:0] streak;
  logic [MW-1:0] misses;

  assign lo     = nominal - GW'(LOCK_TOL);
  assign hi     = nominal + GW'(LOCK_TOL);
  assign rise   = s1 && !s2;
  assign in_win = rise && (gap >= lo) && (gap <= hi);
  assign miss_o = locked && !in_win && (gap > hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      gap    <= '0;
      streak <= '0;
      misses <= '0;
      locked <= 1'b0;
    end else begin
      s1 <= ext_hsync;
      s2 <= s1;
      if (in_win || (!locked && rise)) gap <= GW'(1);
      else if (miss_o)                 gap <= gap - nominal + GW'(1);
      else if (gap != '1)              gap <= gap + GW'(1);

      if (!locked) begin
        if (rise) begin
          if (!in_win) streak <= '0;
          else if (32'(streak) + 1 >= LOCK_COUNT) begin
            locked <= 1'b1;
            streak <= '0;
            misses <= '0;
          end else streak <= streak + SW'(1);
        end
      end else if (in_win) begin
        misses <= '0;
      end else if (miss_o) begin
        if (32'(misses) + 1 >= MISS_COUNT) begin
          locked <= 1'b0;
          misses <= '0;
        end else misses <= misses + MW'(1);
      end
    end
  end

  assign present_o = locked;
  assign accept_o  = in_win;

endmodule

// File: rtl/csync_gen.sv
module csync_gen import csg_pkg::*; #(
  parameter int unsigned LINE_NTSC   = 1820,
  parameter int unsigned LINE_PALM   = 1818,
  parameter int unsigned FRAME_LINES = 525,
  parameter int unsigned HS_TICKS    = 135,
  parameter int unsigned EQ_TICKS    = 66,
  parameter int unsigned SERR_TICKS  = 135,
  parameter int unsigned LOCK_TOL    = 16,
  parameter int unsigned LOCK_COUNT  = 8,
  parameter int unsigned MISS_COUNT  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic std_sel,
  input  logic rate_sel,
  input  logic ext_hsync,
  output logic csync_o,
  output logic h_strobe,
  output logic v_strobe,
  output logic ext_present,
  output logic blue_bg
);

  localparam int unsigned TW = $clog2(LINE_NTSC + 1);
  localparam int unsigned GW = $clog2(LINE_NTSC / 2 + LOCK_TOL + 2) + 1;

  logic          sync_act_w, h_raw_w, v_raw_w, accept_w, miss_w, locked_w;
  logic [TW-1:0] pos_w, half_w;
  logic [GW-1:0] nominal_w;

  assign nominal_w = GW'(line_of(std_sel, LINE_NTSC, LINE_PALM) / step_of(rate_sel));

  csg_timing #(
    .LINE_NTSC(LINE_NTSC), .LINE_PALM(LINE_PALM), .FRAME_LINES(FRAME_LINES),
    .HS_TICKS(HS_TICKS), .EQ_TICKS(EQ_TICKS), .SERR_TICKS(SERR_TICKS)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .rate_sel(rate_sel),
    .sync_act_o(sync_act_w), .h_strobe_o(h_raw_w), .v_strobe_o(v_raw_w),
    .pos_o(pos_w), .half_o(half_w)
  );

  csg_presence #(
    .GW(GW), .LOCK_TOL(LOCK_TOL), .LOCK_COUNT(LOCK_COUNT), .MISS_COUNT(MISS_COUNT)
  ) u_presence (
    .clk(clk), .rst_n(rst_n), .ext_hsync(ext_hsync), .nominal(nominal_w),
    .present_o(locked_w), .accept_o(accept_w), .miss_o(miss_w)
  );

  // In reset the sync pin carries the reference clock itself.
  assign csync_o     = rst_n ? !sync_act_w : clk;
  assign h_strobe    = rst_n && h_raw_w;
  assign v_strobe    = rst_n && v_raw_w;
  assign ext_present = locked_w;
  assign blue_bg     = rst_n && !locked_w;

endmodule

// File: rtl/csync_gen_chk.sv
module csync_gen_chk #(
  parameter int unsigned TW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csync_o,
  input logic          h_strobe,
  input logic          v_strobe,
  input logic          ext_present,
  input logic          accept,
  input logic          miss,
  input logic [TW-1:0] pos,
  input logic [TW-1:0] half
);

  a_r7_hstrobe_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    h_strobe |=> !h_strobe);

  a_r8_vstrobe_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    v_strobe |=> !v_strobe);

  a_r3_hstrobe_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    h_strobe |-> !csync_o);

  a_r8_vstrobe_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    v_strobe |-> !csync_o);

  a_r9_lock_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_present) |-> $past(accept));

  a_r11_loss_follows_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_present) |-> $past(miss));

  a_r2_pos_in_half: assert property (@(posedge clk) disable iff (!rst_n)
    pos < half);

endmodule

bind csync_gen csync_gen_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .csync_o(csync_o), .h_strobe(h_strobe),
  .v_strobe(v_strobe), .ext_present(ext_present), .accept(accept_w),
  .miss(miss_w), .pos(pos_w), .half(half_w)
);

// File: tb/test_csync_gen.sv
module test_csync_gen;
  localparam int CLK_PERIOD = 10;
  localparam int LN = 200, LP = 198, FL = 21, HS = 16, EQ = 8, SERR = 16, TOL = 4;

  typedef struct packed { logic cs; logic hs; logic vs; logic [1:0] rg; } item_t;

  logic clk = 1'b0, rst_n = 1'b0, std_sel = 1'b0, rate_sel = 1'b1, ext_hsync = 1'b0;
  logic csync_o, h_strobe, v_strobe, ext_present, blue_bg;

  int checks = 0, failures = 0, since = 0;
  item_t sbq[$];
  item_t mon_e;

  always #(CLK_PERIOD / 2) clk = ~clk;

  csync_gen #(
    .LINE_NTSC(LN), .LINE_PALM(LP), .FRAME_LINES(FL), .HS_TICKS(HS), .EQ_TICKS(EQ),
    .SERR_TICKS(SERR), .LOCK_TOL(TOL), .LOCK_COUNT(8), .MISS_COUNT(4)
  ) i_csync_gen (
    .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .rate_sel(rate_sel),
    .ext_hsync(ext_hsync), .csync_o(csync_o), .h_strobe(h_strobe),
    .v_strobe(v_strobe), .ext_present(ext_present), .blue_bg(blue_bg)
  );

  task automatic check_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Expected outputs from absolute frame position p (eighth-subcarrier units).
  function automatic item_t model(int p, int lt, int st);
    item_t r;
    int half, fhalf, hla, pos, rel;
    logic low, ls;
    half  = lt / 2;
    fhalf = FL * half;
    hla   = p / half;
    pos   = p % half;
    rel   = (p >= fhalf) ? (p - fhalf) / half : hla;
    ls    = (hla % 2) == 0;
    if (rel < 6 || (rel >= 12 && rel < 18)) begin low = pos < EQ; r.rg = 2'd1; end
    else if (rel < 12) begin low = pos < half - SERR; r.rg = 2'd2; end
    else begin low = ls && pos < HS; r.rg = 2'd0; end
    if (p >= fhalf && rel < 18) r.rg = 2'd3;
    r.cs = !low;
    r.hs = ls && pos < st;
    r.vs = (rel == 6) && pos < st;
    return r;
  endfunction

  // Monitor: pop one expectation per clock and compare.
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      mon_e = sbq.pop_front();
      checks++;
      if ({csync_o, h_strobe, v_strobe} != {mon_e.cs, mon_e.hs, mon_e.vs}) begin
        failures++;
        if (csync_o != mon_e.cs)
          $display("FAIL %s csync actual=%b expected=%b",
                   (mon_e.rg == 2'd0) ? "R3" : (mon_e.rg == 2'd1) ? "R4" :
                   (mon_e.rg == 2'd2) ? "R5" : "R6", csync_o, mon_e.cs);
        else if (h_strobe != mon_e.hs)
          $display("FAIL R7 h_strobe actual=%b expected=%b", h_strobe, mon_e.hs);
        else
          $display("FAIL R8 v_strobe actual=%b expected=%b", v_strobe, mon_e.vs);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
    since += n;
  endtask

  task automatic pulse(int iv);
    tick(iv - since);
    ext_hsync = 1'b1;
    since = 0;
    tick(3);
    ext_hsync = 1'b0;
  endtask

  task automatic reset_mode(logic s, logic r);
    rst_n = 1'b0; std_sel = s; rate_sel = r; ext_hsync = 1'b0;
    repeat (2) @(posedge clk);
    #1 check_eq("R1", "csync high phase", csync_o, 1);
    @(negedge clk);
    #1 check_eq("R1", "csync low phase", csync_o, 0);
    check_eq("R1", "strobes/present/blue", {h_strobe, v_strobe, ext_present, blue_bg}, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    since = 0;
  endtask

  task automatic run_frame(logic s, logic r);
    int st, lt, f, p, cnt, seen;
    st = r ? 2 : 4;
    lt = s ? LP : LN;
    f  = FL * lt;
    reset_mode(s, r);
    p = 0;
    sbq.push_back(model(p, lt, st));
    repeat (f / st + 40) begin
      @(posedge clk); #1;
      p = (p + st) % f;
      sbq.push_back(model(p, lt, st));
    end
    @(negedge clk); #1;
    // R2: two lines span 2*line/step clocks.
    do @(negedge clk); while (h_strobe !== 1'b1);
    cnt = 0; seen = 0;
    while (seen < 2) begin
      @(negedge clk);
      cnt++;
      if (h_strobe) seen++;
    end
    check_eq("R2", "clocks per two lines", cnt, 2 * lt / st);
  endtask

  initial begin
    run_frame(1'b0, 1'b1);
    run_frame(1'b0, 1'b0);
    run_frame(1'b1, 1'b1);
    run_frame(1'b1, 1'b0);

    // Presence detector, NTSC 4x: nominal 100 clocks, window 96..104.
    reset_mode(1'b0, 1'b1);
    pulse(10);
    repeat (7) pulse(100);
    tick(10);
    check_eq("R9", "present after 7 intervals", ext_present, 0);
    check_eq("R12", "blue while internal", blue_bg, 1);
    pulse(100);
    tick(10);
    check_eq("R9", "present after 8 intervals", ext_present, 1);
    check_eq("R12", "blue while external", blue_bg, 0);

    tick(50 - since);
    ext_hsync = 1'b1; tick(3); ext_hsync = 1'b0;
    pulse(100);
    tick(10);
    check_eq("R11", "early pulse ignored", ext_present, 1);
    pulse(400);
    tick(10);
    check_eq("R11", "three misses tolerated", ext_present, 1);
    pulse(400);
    tick(10);
    check_eq("R11", "misses cleared by good edge", ext_present, 1);
    tick(355 - since);
    check_eq("R11", "present after three missed windows", ext_present, 1);
    tick(100);
    check_eq("R11", "lost after four missed windows", ext_present, 0);
    check_eq("R12", "blue after loss", blue_bg, 1);

    pulse(460);
    repeat (5) pulse(100);
    pulse(105);
    pulse(104);
    pulse(96);
    repeat (5) pulse(100);
    tick(10);
    check_eq("R10", "streak restarted by bad interval", ext_present, 0);
    pulse(100);
    tick(10);
    check_eq("R10", "lock after 8 good incl. window edges", ext_present, 1);

    rst_n = 1'b0;
    @(negedge clk);
    #1 check_eq("R1", "present cleared in reset", ext_present, 0);
    check_eq("R1", "csync follows clock in reset", csync_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule